// File: doc/BRIEF.md
# Chained-Descriptor Source DMA Walker

This block reads source data from memory and hands it to a hash core as a stream of 32-bit words, each tagged with how many of its bytes are valid. It can work in two ways. In the plain mode it reads one buffer, given by a start address and a byte count. In the chained mode it reads a list of 16-byte records held in memory. Each record gives a buffer address, a byte count, the address of the next record and a flags word. The walker reads a record, streams that buffer, then moves on to the next record. It stops after a record whose flags word has its top bit set.

Software sets up the block through a small write/read register port. A write to the control register that sets the run bit starts a transfer. The block reports the end of the transfer, or a fault, in a status register whose bits are cleared by writing one. An enable register chooses which status bits can raise the interrupt, and a single mask bit gates the interrupt line. Memory is reached through a simple port with one read in flight at a time. Each request carries a 3-bit cache attribute taken from the control register.

Top module: `dma_chain_walker`

## Requirements
- R1: After reset, mem_req, out_valid and irq are 0, and the status register (offset 0x480) reads 0.
- R2: In plain mode (control bit 25 clear), the block reads the words at the start address (0x400), rising by 4 each time, and sends every word out. It issues exactly ceil(length/4) data reads, where the length is the value at 0x408. A word that is offered and not taken keeps its data and byte count unchanged.
- R3: In chained mode (control bit 25 set), the first record is read from the address at 0x418. Its four words are read at +0, +4, +8 and +12 and hold the buffer address, the byte count, the next-record address and the flags. After a record whose flags bit 31 is 1, no further record is read.
- R4: A record whose byte count is zero causes no data reads and no output words.
- R5: out_nbytes is 4 for every full word. For the last word of a buffer it equals the bytes left (1 to 4).
- R6: Status bit 0 (source done) is set once, when the last word of the final buffer is accepted. In plain mode with a zero length it is set straight away. The run bit (control bit 31) then reads 0.
- R7: An error response to a memory read sets status bit 4. It stops the transfer, clears the run bit, sends no further words and leaves bit 0 clear.
- R8: Writing to the status register clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R9: irq equals bit 0 of the mask register (0x488) ANDed with the OR of (status AND enable register 0x484).
- R10: Writes to the control register while the run bit is set have no effect. Control bits 30:28 appear on mem_attr during a transfer.
- R11: mem_req is high for one cycle per read, and a new read is issued only after the previous read has been answered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational from reg_addr) |
| mem_req | output | 1 | Memory read request, one cycle |
| mem_addr | output | AW | Memory read byte address |
| mem_attr | output | 3 | Cache attribute for the request |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 32 | Read response data |
| mem_rerr | input | 1 | Read response error |
| out_valid | output | 1 | Output word valid |
| out_data | output | 32 | Output word |
| out_nbytes | output | 3 | Count of valid bytes in out_data |
| out_ready | input | 1 | Downstream accepts the word |
| irq | output | 1 | Interrupt |

## Verification
The checker watches, on every cycle, the rules that can be seen locally:

- Single-cycle, non-overlapping memory requests.
- An output word that stays stable while it is stalled.
- Byte counts that stay within 1 to 4.
- The run bit clearing whenever source done rises.
- Source done never rising together with the read-error bit.

Other behaviour only shows up over a whole transfer, so the bench's scenarios cover it. This includes:

- Which addresses are read, and that reading stops at the record that ends the chain.
- Skipping a zero-length record.
- The exact word sequence compared through the scoreboard.
- Register clear-on-write behaviour.
- Interrupt gating.
- Control writes being ignored while a transfer runs.

// File: rtl/dma_chain_walker.sv
module dma_chain_walker #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [11:0]   reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [2:0]    mem_attr,
  input  logic          mem_rvalid,
  input  logic [31:0]   mem_rdata,
  input  logic          mem_rerr,
  output logic          out_valid,
  output logic [31:0]   out_data,
  output logic [2:0]    out_nbytes,
  input  logic          out_ready,
  output logic          irq
);
  localparam logic [11:0] A_SRC  = 12'h400;
  localparam logic [11:0] A_SIZE = 12'h408;
  localparam logic [11:0] A_CTRL = 12'h410;
  localparam logic [11:0] A_NEXT = 12'h418;
  localparam logic [11:0] A_STS  = 12'h480;
  localparam logic [11:0] A_IEN  = 12'h484;
  localparam logic [11:0] A_MSK  = 12'h488;
  localparam int SW = 9;
  localparam logic [LW-1:0] FOUR = LW'(4);

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_RREQ, S_RWAIT, S_SEND} st_t;
  st_t st;

  logic          run, chain, last;
  logic [2:0]    snoop;
  logic [AW-1:0] src_q, next_q, ptr, nxt, cur;
  logic [LW-1:0] size_q, rem;
  logic [SW-1:0] sts, ien;
  logic          msk;
  logic [1:0]    widx;
  logic [31:0]   dat;

  wire ctrl_wr = reg_we && reg_addr == A_CTRL && !run;
  wire start   = ctrl_wr && reg_wdata[31];
  wire rsp_ok  = mem_rvalid && !mem_rerr;
  wire desc_end = st == S_DWAIT && rsp_ok && widx == 2'd3;
  wire word_acc = st == S_SEND && out_ready;
  wire buf_end  = rem <= FOUR;

  wire fin = (st == S_IDLE && start && !reg_wdata[25] && size_q == '0)
          || (desc_end && rem == '0 && mem_rdata[31])
          || (word_acc && buf_end && last);
  wire abort = (st == S_DWAIT || st == S_RWAIT) && mem_rvalid && mem_rerr;

  wire [SW-1:0] sts_set = {4'b0, abort, 3'b0, fin};
  wire [SW-1:0] sts_clr = (reg_we && reg_addr == A_STS) ? reg_wdata[SW-1:0] : '0;

  assign mem_req    = st == S_DREQ || st == S_RREQ;
  assign mem_addr   = st == S_DREQ ? ptr + AW'({widx, 2'b00}) : cur;
  assign mem_attr   = snoop;
  assign out_valid  = st == S_SEND;
  assign out_data   = dat;
  assign out_nbytes = buf_end ? rem[2:0] : 3'd4;
  assign irq        = msk && |(sts & ien);

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = 32'(src_q);
      A_SIZE:  reg_rdata = 32'(size_q);
      A_CTRL:  reg_rdata = {run, snoop, 2'b0, chain, 25'b0};
      A_NEXT:  reg_rdata = 32'(next_q);
      A_STS:   reg_rdata = 32'(sts);
      A_IEN:   reg_rdata = 32'(ien);
      A_MSK:   reg_rdata = {31'b0, msk};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= '0; size_q <= '0; next_q <= '0;
      ien <= '0; msk <= 1'b0; sts <= '0;
      run <= 1'b0; chain <= 1'b0; snoop <= '0;
    end else begin
      if (reg_we && reg_addr == A_SRC)  src_q  <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == A_SIZE) size_q <= reg_wdata[LW-1:0];
      if (reg_we && reg_addr == A_NEXT) next_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == A_IEN)  ien    <= reg_wdata[SW-1:0];
      if (reg_we && reg_addr == A_MSK)  msk    <= reg_wdata[0];
      if (ctrl_wr) begin
        chain <= reg_wdata[25];
        snoop <= reg_wdata[30:28];
      end
      sts <= (sts & ~sts_clr) | sts_set;
      if (fin || abort) run <= 1'b0;
      else if (start)   run <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ptr <= '0; nxt <= '0; cur <= '0; rem <= '0;
      last <= 1'b0; widx <= '0; dat <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          if (reg_wdata[25]) begin
            ptr <= next_q; widx <= '0; st <= S_DREQ;
          end else begin
            cur <= src_q; rem <= size_q; last <= 1'b1;
            st <= (size_q == '0) ? S_IDLE : S_RREQ;
          end
        end
        S_DREQ: st <= S_DWAIT;
        S_DWAIT: if (mem_rvalid) begin
          if (mem_rerr) st <= S_IDLE;
          else begin
            case (widx)
              2'd0: cur <= mem_rdata[AW-1:0];
              2'd1: rem <= mem_rdata[LW-1:0];
              2'd2: nxt <= mem_rdata[AW-1:0];
              default: last <= mem_rdata[31];
            endcase
            widx <= widx + 2'd1;
            if (widx != 2'd3)      st <= S_DREQ;
            else if (rem != '0)    st <= S_RREQ;
            else if (mem_rdata[31]) st <= S_IDLE;
            else begin ptr <= nxt; st <= S_DREQ; end
          end
        end
        S_RREQ: st <= S_RWAIT;
        S_RWAIT: if (mem_rvalid) begin
          if (mem_rerr) st <= S_IDLE;
          else begin dat <= mem_rdata; st <= S_SEND; end
        end
        S_SEND: if (out_ready) begin
          rem <= buf_end ? '0 : rem - FOUR;
          cur <= cur + AW'(4);
          if (!buf_end)  st <= S_RREQ;
          else if (last) st <= S_IDLE;
          else begin ptr <= nxt; widx <= '0; st <= S_DREQ; end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module dma_chain_walker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_req,
  input logic       mem_rvalid,
  input logic       out_valid,
  input logic       out_ready,
  input logic [31:0] out_data,
  input logic [2:0] out_nbytes,
  input logic       done_bit,
  input logic       rderr_bit,
  input logic       run
);
  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R11
  AST_REQ_NOT_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rvalid |-> !mem_req); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_nbytes)); // R2
  AST_NBYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_nbytes != 3'd0 && out_nbytes <= 3'd4); // R5
  AST_DONE_STOPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_bit) |-> !run); // R6
  AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rderr_bit) |-> !$rose(done_bit)); // R7
endmodule

bind dma_chain_walker dma_chain_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rvalid(mem_rvalid),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_nbytes(out_nbytes), .done_bit(sts[0]), .rderr_bit(sts[4]), .run(run));

// File: tb/tb_dma_chain_walker.sv
module tb_dma_chain_walker;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mem_req, mem_rvalid = 0, mem_rerr = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic [2:0] mem_attr, out_nbytes;
  logic out_valid, out_ready = 0, irq;
  logic [31:0] out_data;

  dma_chain_walker dut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  int req_count = 0, stray = 0, attr_bad = 0;
  logic [2:0] exp_attr = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic [31:0] mem [0:255];
  logic [31:0] pend_addr = 0;
  int pend = 0;
  logic [7:0] lfsr = 8'h5A;
  logic [34:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= lfsr[0] | lfsr[2];
    mem_rvalid <= 1'b0;
    if (pend == 1) begin
      mem_rvalid <= 1'b1;
      mem_rdata <= mem[pend_addr[9:2]];
      mem_rerr <= (pend_addr == err_addr);
    end
    if (pend != 0) pend <= pend - 1;
    if (mem_req) begin
      pend_addr <= mem_addr; pend <= 2;
      req_count <= req_count + 1;
      if (mem_addr >= 32'h230 && mem_addr < 32'h240) stray <= stray + 1;
      if (mem_attr != exp_attr) attr_bad <= attr_bad + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) chk(0, "R2 unexpected word", out_data, 0);
      else begin
        logic [34:0] e;
        e = expq.pop_front();
        chk(out_data == e[31:0], "R2 data", out_data, e[31:0]);
        chk(out_nbytes == e[34:32], "R5 nbytes", 32'(out_nbytes), 32'(e[34:32]));
      end
    end
  end

  initial begin
    wait (cycles > 100000);
    chk(0, "watchdog", cycles, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic push_buf(input logic [31:0] a, input int len);
    for (int i = 0; i < len; i += 4)
      expq.push_back({3'((len - i) >= 4 ? 4 : len - i), mem[(a + i) >> 2]});
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'h8000_0000;
    for (int n = 0; n < 2000 && v[31]; n++) rd(12'h410, v);
    repeat (4) @(negedge clk);
  endtask

  task automatic set_desc(input int base, input logic [31:0] a, l, n, f);
    mem[base >> 2] = a; mem[(base >> 2) + 1] = l;
    mem[(base >> 2) + 2] = n; mem[(base >> 2) + 3] = f;
  endtask

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + (i * 32'h0101);
    set_desc(32'h200, 32'h300, 8, 32'h210, 0);
    set_desc(32'h210, 32'h340, 0, 32'h220, 0);
    set_desc(32'h220, 32'h380, 5, 32'h230, 32'h8000_0000);
    set_desc(32'h230, 32'h3C0, 8, 32'h200, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req == 0 && out_valid == 0 && irq == 0, "R1 outputs", {mem_req, out_valid, irq}, 0);
    rst_n = 1;
    rd(12'h480, v); chk(v == 0, "R1 status", v, 0);

    // R2 R5 R6 R9 R10 plain mode
    wr(12'h484, 32'h1FD); wr(12'h488, 1);
    wr(12'h400, 32'h100); wr(12'h408, 10);
    exp_attr = 3'd3; req_count = 0;
    push_buf(32'h100, 10);
    wr(12'h410, 32'h8000_0000 | (32'd3 << 28));
    wait_idle();
    chk(expq.size() == 0, "R2 all words", expq.size(), 0);
    chk(req_count == 3, "R2 read count", req_count, 3);
    chk(attr_bad == 0, "R10 attr", attr_bad, 0);
    rd(12'h480, v); chk(v == 1, "R6 done", v, 1);
    rd(12'h410, v); chk(v[31] == 0, "R6 run cleared", v, 0);
    chk(irq == 1, "R9 irq on", irq, 1);

    // R8 W1C
    wr(12'h480, 0); rd(12'h480, v); chk(v == 1, "R8 zero write keeps", v, 1);
    wr(12'h480, 1); rd(12'h480, v); chk(v == 0, "R8 one clears", v, 0);
    chk(irq == 0, "R9 irq off", irq, 0);

    // R3 R4 R5 chained, R10 writes ignored while running, R9 mask
    wr(12'h488, 0); wr(12'h418, 32'h200);
    exp_attr = 3'd5; req_count = 0; stray = 0;
    push_buf(32'h300, 8); push_buf(32'h380, 5);
    wr(12'h410, 32'h8200_0000 | (32'd5 << 28));
    wr(12'h410, 32'h0000_0000);
    wr(12'h410, 32'h8000_0000);
    wait_idle();
    chk(expq.size() == 0, "R3 chain words", expq.size(), 0);
    chk(req_count == 16, "R4 read count", req_count, 16);
    chk(stray == 0, "R3 stop at end flag", stray, 0);
    chk(attr_bad == 0, "R10 attr kept", attr_bad, 0);
    rd(12'h410, v); chk(v == 32'h5200_0000, "R10 ctrl unchanged", v, 32'h5200_0000);
    rd(12'h480, v); chk(v == 1, "R6 chain done", v, 1);
    chk(irq == 0, "R9 masked", irq, 0);
    wr(12'h480, 32'h1FF);

    // R6 zero length plain
    wr(12'h408, 0); req_count = 0; exp_attr = 0;
    wr(12'h410, 32'h8000_0000); wait_idle();
    chk(req_count == 0, "R6 zero len no reads", req_count, 0);
    rd(12'h480, v); chk(v == 1, "R6 zero len done", v, 1);
    wr(12'h480, 32'h1FF);

    // R7 data read error
    wr(12'h488, 1); wr(12'h408, 16); err_addr = 32'h108; req_count = 0;
    push_buf(32'h100, 8);
    wr(12'h410, 32'h8000_0000); wait_idle();
    repeat (20) @(negedge clk);
    chk(expq.size() == 0, "R7 words before error", expq.size(), 0);
    chk(req_count == 3, "R7 abort reads", req_count, 3);
    rd(12'h480, v); chk(v == 32'h10, "R7 status", v, 32'h10);
    chk(irq == 1, "R9 err irq", irq, 1);
    wr(12'h480, 32'h1FF);

    // R7 descriptor read error
    err_addr = 32'h208; req_count = 0;
    wr(12'h410, 32'h8200_0000); wait_idle();
    chk(req_count == 3, "R7 desc abort reads", req_count, 3);
    rd(12'h480, v); chk(v == 32'h10, "R7 desc status", v, 32'h10);
    rd(12'h410, v); chk(v[31] == 0, "R7 run cleared", v, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule